// File: doc/BRIEF.md
# Flash Page Buffer Command Controller

This block sits in front of a paged nonvolatile array and manages the single page buffer that holds the page being edited. It keeps track of which page the buffer holds, whether that copy has been changed, and whether the change is shielded against being lost. It serves two commands. Unprotect Page lifts the shield for a page and brings that page into the buffer if it is not already there. Discard Page throws away pending edits. Each command raises a busy flag and ends with a two-bit completion code.

The array itself is modelled as a small bank of per-block error flags. A page fetch walks the page one word per cycle and collects these flags, so a correctable and an uncorrectable read error can be told apart. The array is indexed by the low bits of the page number, so page numbers that differ only in their upper bits share one set of flags. A separate buffer-write strobe stands in for the write path. It marks the resident page as changed and, when the loss-protect input is high, also marks it as shielded.

Top module: `flash_pgbuf_ctrl`

## Requirements
- R1: After a synchronous active-low reset, busy is low, status is 2'b00, no page is resident, and the buffer is neither modified nor protected.
- R2: Unprotect Page on the resident page takes one busy cycle. It clears the protection, keeps the modified flag, performs no fetch and reports 2'b00.
- R3: Unprotect Page on a page that is not resident, when no refusal applies, fetches the page. Busy is high for WORDS_PER_PAGE cycles. Afterwards that page is resident, unmodified and unprotected. The page number is addr_i[17:3].
- R4: Unprotect Page is refused with status 2'b11 after one busy cycle when three conditions hold: the page differs from the resident page, the buffer is modified, and either loss_prot_i is high at acceptance or the resident page is protected. On refusal the resident page, the modified flag and the protection flag are unchanged.
- R5: A fetch that meets only correctable block flags reports 2'b01.
- R6: A fetch that meets any uncorrectable block flag reports 2'b10, even when correctable flags are also present, and the page still becomes resident.
- R7: Discard Page takes one busy cycle, clears the modified and protection flags, keeps the resident page and reports 2'b00.
- R8: Busy rises on the clock edge that accepts a command. Status changes only on the edge where busy falls and holds its value at all other times.
- R9: Command strobes and buffer writes that arrive while busy are ignored. A buffer write is also ignored when no page is resident.
- R10: When both command strobes are high in the same idle cycle, Discard Page is performed.
- R11: A buffer write made while idle, with a page resident and no command strobe high, sets the modified flag. If loss_prot_i is also high, it sets the protection flag as well. Protection never stands without modification.
- R12: Error flags are written through the injection port. The flags are indexed by the page index (low 4 bits of the page number) and the block (word offset divided by WORDS_PER_BLOCK, one bit). A fetch reads the flags of the page index of the page it is fetching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unprot_req_i | input | 1 | Unprotect Page strobe |
| discard_req_i | input | 1 | Discard Page strobe |
| addr_i | input | 18 | Word address; the upper 15 bits select the page |
| loss_prot_i | input | 1 | Loss-protect qualifier for commands and buffer writes |
| buf_wr_i | input | 1 | Buffer-write notification |
| inj_we_i | input | 1 | Error flag write enable |
| inj_page_i | input | 4 | Page index of the error flag write |
| inj_blk_i | input | 1 | Block index of the error flag write |
| inj_ce_i | input | 1 | Correctable flag value |
| inj_ue_i | input | 1 | Uncorrectable flag value |
| busy_o | output | 1 | Command in progress |
| status_o | output | 2 | Completion code: 00 ok, 01 correctable, 10 uncorrectable, 11 refused |
| res_valid_o | output | 1 | A page is resident |
| res_page_o | output | 15 | Resident page number |
| modified_o | output | 1 | Buffer holds unsaved changes |
| protected_o | output | 1 | Buffer changes are loss-protected |

## Verification
The assertions assume that the error flags of a page are not rewritten while that page is being fetched. They also assume reset is held for at least one clock edge before the first command. The stimulus writes flags only while the block is idle and holds reset for several cycles. A behavioural model in the bench predicts busy, status and the buffer state on every clock. Directed steps provoke a refusal by an explicit qualifier and a refusal by stored protection, mixed error flags, aliased page numbers, simultaneous strobes, and commands and writes issued during a fetch.

// File: rtl/pbc_pkg.sv
// Package: shared encodings for the page buffer command controller.
// Assumes: status codes are observed by software exactly as listed here.
package pbc_pkg;

    typedef enum logic [1:0] {
        ST_OK       = 2'b00,
        ST_CORR     = 2'b01,
        ST_UNCORR   = 2'b10,
        ST_REFUSED  = 2'b11
    } pbc_status_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHORT = 2'd1,
        PH_COPY  = 2'd2
    } pbc_phase_e;

    typedef enum logic [1:0] {
        ACT_NONE       = 2'd0,
        ACT_DISCARD    = 2'd1,
        ACT_UNPROT_HIT = 2'd2,
        ACT_REFUSE     = 2'd3
    } pbc_act_e;

endpackage

// File: rtl/pbc_err_store.sv
// Module: pbc_err_store
// Holds one correctable and one uncorrectable flag per block of every
// modelled page, written through a test port and read by the fetch walker.
// Assumes: BLOCKS divides the index space evenly; indices arrive in range.
module pbc_err_store #(
    parameter int NUM_PAGES = 16,
    parameter int BLOCKS    = 2,
    parameter int PIDX_W    = 4,
    parameter int BLK_W     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PIDX_W-1:0] wr_page_i,
    input  logic [BLK_W-1:0]  wr_blk_i,
    input  logic              wr_ce_i,
    input  logic              wr_ue_i,
    input  logic [PIDX_W-1:0] rd_page_i,
    input  logic [BLK_W-1:0]  rd_blk_i,
    output logic              rd_ce_o,
    output logic              rd_ue_o
);

    localparam int TOTAL = NUM_PAGES * BLOCKS;
    localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;

    logic [TOTAL-1:0] ce_q;
    logic [TOTAL-1:0] ue_q;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    // Flatten page and block into a flag index.
    always_comb begin
        wr_idx = IDX_W'(wr_page_i) * IDX_W'(BLOCKS) + IDX_W'(wr_blk_i);
        rd_idx = IDX_W'(rd_page_i) * IDX_W'(BLOCKS) + IDX_W'(rd_blk_i);
    end

    // Store flag writes; all flags clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q <= '0;
            ue_q <= '0;
        end else if (wr_en_i && (int'(wr_idx) < TOTAL)) begin
            ce_q[wr_idx] <= wr_ce_i;
            ue_q[wr_idx] <= wr_ue_i;
        end
    end

    // Present the flags of the addressed block.
    always_comb begin
        rd_ce_o = 1'b0;
        rd_ue_o = 1'b0;
        if (int'(rd_idx) < TOTAL) begin
            rd_ce_o = ce_q[rd_idx];
            rd_ue_o = ue_q[rd_idx];
        end
    end

    // R12: a flag write lands in the addressed slot by the next cycle.
    p_inj_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && (rd_idx == wr_idx) && (int'(wr_idx) < TOTAL)
        |=> ($past(rd_idx) != rd_idx) || (rd_ue_o == $past(wr_ue_i)));

endmodule

// File: rtl/pbc_copy_walker.sv
// Module: pbc_copy_walker
// Steps through a page one word per cycle and ORs together the error flags
// of the blocks it passes, giving an end-of-page error summary.
// Assumes: start_i is never raised while a walk is active.
module pbc_copy_walker #(
    parameter int WORDS = 8,
    parameter int WPB   = 4,
    parameter int BLK_W = 1,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             word_ce_i,
    input  logic             word_ue_i,
    output logic             active_o,
    output logic [BLK_W-1:0] blk_o,
    output logic             last_o,
    output logic             ce_any_o,
    output logic             ue_any_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic             ce_acc_q;
    logic             ue_acc_q;

    // Current block, last-word flag and running error summary.
    always_comb begin
        blk_o    = BLK_W'(cnt_q / CNT_W'(WPB));
        last_o   = active_q && (cnt_q == CNT_W'(WORDS - 1));
        ce_any_o = ce_acc_q | word_ce_i;
        ue_any_o = ue_acc_q | word_ue_i;
        active_o = active_q;
    end

    // Advance the word counter and collect flags word by word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            ce_acc_q <= 1'b0;
            ue_acc_q <= 1'b0;
        end else if (start_i) begin
            cnt_q    <= '0;
            active_q <= 1'b1;
            ce_acc_q <= 1'b0;
            ue_acc_q <= 1'b0;
        end else if (active_q) begin
            ce_acc_q <= ce_acc_q | word_ce_i;
            ue_acc_q <= ue_acc_q | word_ue_i;
            if (last_o) active_q <= 1'b0;
            else        cnt_q    <= cnt_q + 1'b1;
        end
    end

    // R3: every walk begins at word zero with a clean summary.
    p_walk_fresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> active_q && (cnt_q == '0) && !ce_acc_q && !ue_acc_q);

    // R8: the walk stops right after its last word.
    p_walk_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && !start_i |=> !active_q);

endmodule

// File: rtl/pbc_buf_state.sv
// Module: pbc_buf_state
// Records which page the buffer holds and its modified and protected flags.
// Assumes: at most one of load, discard and unprotect is high per cycle.
module pbc_buf_state #(
    parameter int PN_W = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [PN_W-1:0] load_page_i,
    input  logic            discard_i,
    input  logic            unprot_i,
    input  logic            write_i,
    input  logic            write_prot_i,
    output logic            valid_o,
    output logic [PN_W-1:0] page_o,
    output logic            mod_o,
    output logic            prot_o
);

    logic            valid_q;
    logic [PN_W-1:0] page_q;
    logic            mod_q;
    logic            prot_q;

    // Apply the one buffer event of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            page_q  <= '0;
            mod_q   <= 1'b0;
            prot_q  <= 1'b0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            page_q  <= load_page_i;
            mod_q   <= 1'b0;
            prot_q  <= 1'b0;
        end else if (discard_i) begin
            mod_q   <= 1'b0;
            prot_q  <= 1'b0;
        end else if (unprot_i) begin
            prot_q  <= 1'b0;
        end else if (write_i && valid_q) begin
            mod_q   <= 1'b1;
            prot_q  <= prot_q | write_prot_i;
        end
    end

    assign valid_o = valid_q;
    assign page_o  = page_q;
    assign mod_o   = mod_q;
    assign prot_o  = prot_q;

    // R11: protection only ever covers a modified buffer.
    p_prot_needs_mod_r11: assert property (@(posedge clk) disable iff (!rst_n)
        prot_q |-> mod_q);

    // R3: a fetched page arrives clean.
    p_load_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> valid_q && !mod_q && !prot_q && (page_q == $past(load_page_i)));

    // R9: a write with no resident page changes nothing.
    p_write_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        write_i && !valid_q && !load_i |=> !mod_q);

endmodule

// File: rtl/flash_pgbuf_ctrl.sv
// Module: flash_pgbuf_ctrl
// Accepts Unprotect Page and Discard Page commands, decides between hit,
// refusal and fetch, sequences the fetch and reports a completion code.
// Assumes: WORDS_PER_PAGE and WORDS_PER_BLOCK are powers of two, with
// WORDS_PER_PAGE >= 2, and MODEL_PAGES <= 2**(page number width).
module flash_pgbuf_ctrl
    import pbc_pkg::*;
#(
    parameter int ADDR_W          = 18,
    parameter int WORDS_PER_PAGE  = 8,
    parameter int WORDS_PER_BLOCK = 4,
    parameter int MODEL_PAGES     = 16,
    localparam int OFS_W  = $clog2(WORDS_PER_PAGE),
    localparam int PN_W   = ADDR_W - OFS_W,
    localparam int BLOCKS = WORDS_PER_PAGE / WORDS_PER_BLOCK,
    localparam int BLK_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
    localparam int PIDX_W = (MODEL_PAGES > 1) ? $clog2(MODEL_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unprot_req_i,
    input  logic              discard_req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              loss_prot_i,
    input  logic              buf_wr_i,
    input  logic              inj_we_i,
    input  logic [PIDX_W-1:0] inj_page_i,
    input  logic [BLK_W-1:0]  inj_blk_i,
    input  logic              inj_ce_i,
    input  logic              inj_ue_i,
    output logic              busy_o,
    output logic [1:0]        status_o,
    output logic              res_valid_o,
    output logic [PN_W-1:0]   res_page_o,
    output logic              modified_o,
    output logic              protected_o
);

    pbc_phase_e      phase_q;
    pbc_act_e        act_q;
    pbc_status_e     status_q;
    logic [PN_W-1:0] target_q;

    logic [PN_W-1:0]  req_page;
    logic             idle;
    logic             hit;
    logic             refuse;
    logic             start_copy;
    logic             walk_active;
    logic             walk_last;
    logic             walk_ce;
    logic             walk_ue;
    logic [BLK_W-1:0] walk_blk;
    logic             word_ce;
    logic             word_ue;

    // Decode the request against the current buffer state.
    always_comb begin
        req_page   = addr_i[ADDR_W-1:OFS_W];
        idle       = (phase_q == PH_IDLE);
        hit        = res_valid_o && (res_page_o == req_page);
        refuse     = !hit && modified_o && (loss_prot_i || protected_o);
        start_copy = idle && !discard_req_i && unprot_req_i && !hit && !refuse;
    end

    // Command sequencer: accept, run and complete one command at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            act_q    <= ACT_NONE;
            status_q <= ST_OK;
            target_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (discard_req_i) begin
                        phase_q <= PH_SHORT;
                        act_q   <= ACT_DISCARD;
                    end else if (unprot_req_i) begin
                        if (hit) begin
                            phase_q <= PH_SHORT;
                            act_q   <= ACT_UNPROT_HIT;
                        end else if (refuse) begin
                            phase_q <= PH_SHORT;
                            act_q   <= ACT_REFUSE;
                        end else begin
                            phase_q  <= PH_COPY;
                            act_q    <= ACT_NONE;
                            target_q <= req_page;
                        end
                    end
                end
                PH_SHORT: begin
                    phase_q  <= PH_IDLE;
                    status_q <= (act_q == ACT_REFUSE) ? ST_REFUSED : ST_OK;
                end
                PH_COPY: begin
                    if (walk_last) begin
                        phase_q  <= PH_IDLE;
                        status_q <= walk_ue ? ST_UNCORR :
                                    walk_ce ? ST_CORR   : ST_OK;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy_o   = !idle;
    assign status_o = status_q;

    pbc_err_store #(
        .NUM_PAGES (MODEL_PAGES),
        .BLOCKS    (BLOCKS),
        .PIDX_W    (PIDX_W),
        .BLK_W     (BLK_W)
    ) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (inj_we_i),
        .wr_page_i (inj_page_i),
        .wr_blk_i  (inj_blk_i),
        .wr_ce_i   (inj_ce_i),
        .wr_ue_i   (inj_ue_i),
        .rd_page_i (target_q[PIDX_W-1:0]),
        .rd_blk_i  (walk_blk),
        .rd_ce_o   (word_ce),
        .rd_ue_o   (word_ue)
    );

    pbc_copy_walker #(
        .WORDS (WORDS_PER_PAGE),
        .WPB   (WORDS_PER_BLOCK),
        .BLK_W (BLK_W),
        .CNT_W (OFS_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_copy),
        .word_ce_i (word_ce),
        .word_ue_i (word_ue),
        .active_o  (walk_active),
        .blk_o     (walk_blk),
        .last_o    (walk_last),
        .ce_any_o  (walk_ce),
        .ue_any_o  (walk_ue)
    );

    pbc_buf_state #(
        .PN_W (PN_W)
    ) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       ((phase_q == PH_COPY) && walk_last),
        .load_page_i  (target_q),
        .discard_i    ((phase_q == PH_SHORT) && (act_q == ACT_DISCARD)),
        .unprot_i     ((phase_q == PH_SHORT) && (act_q == ACT_UNPROT_HIT)),
        .write_i      (idle && buf_wr_i && !discard_req_i && !unprot_req_i),
        .write_prot_i (loss_prot_i),
        .valid_o      (res_valid_o),
        .page_o       (res_page_o),
        .mod_o        (modified_o),
        .prot_o       (protected_o)
    );

    // R1: leaving reset the block is idle with nothing resident.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !busy_o && (status_o == 2'b00) && !res_valid_o);

    // R2: one-cycle commands end after a single busy cycle.
    p_short_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SHORT) |=> !busy_o);

    // R4: a refusal reports 2'b11 and keeps the resident page.
    p_refuse_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SHORT) && (act_q == ACT_REFUSE)
        |=> (status_o == 2'b11) && $stable(res_page_o) && $stable(modified_o));

    // R8: status moves only when busy falls.
    p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy_o) |-> $stable(status_o));

    // R3: the fetch phase and the walker stay in step.
    p_copy_walk_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_COPY) |-> walk_active);

    // R9: an unfinished fetch keeps busy high whatever the strobes do.
    p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_COPY) && !walk_last |=> busy_o);

    // R10: simultaneous strobes select the discard.
    p_discard_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle && discard_req_i && unprot_req_i |=> (act_q == ACT_DISCARD));

endmodule

// File: tb/test_flash_pgbuf_ctrl.sv
`timescale 1ns/1ps
module test_flash_pgbuf_ctrl;

    localparam int WORDS = 8;
    localparam int BL    = 2;
    localparam int NP    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unprot_req = 1'b0;
    logic        discard_req = 1'b0;
    logic [17:0] addr = '0;
    logic        lp = 1'b0;
    logic        buf_wr = 1'b0;
    logic        inj_we = 1'b0;
    logic [3:0]  inj_page = '0;
    logic        inj_blk = 1'b0;
    logic        inj_ce = 1'b0;
    logic        inj_ue = 1'b0;
    logic        busy;
    logic [1:0]  status;
    logic        res_valid;
    logic [14:0] res_page;
    logic        modified;
    logic        protect;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    flash_pgbuf_ctrl i_flash_pgbuf_ctrl (
        .clk (clk), .rst_n (rst_n),
        .unprot_req_i (unprot_req), .discard_req_i (discard_req),
        .addr_i (addr), .loss_prot_i (lp), .buf_wr_i (buf_wr),
        .inj_we_i (inj_we), .inj_page_i (inj_page), .inj_blk_i (inj_blk),
        .inj_ce_i (inj_ce), .inj_ue_i (inj_ue),
        .busy_o (busy), .status_o (status), .res_valid_o (res_valid),
        .res_page_o (res_page), .modified_o (modified), .protected_o (protect)
    );

    // Behavioural reference model, advanced on each rising edge.
    bit m_ce [NP*BL];
    bit m_ue [NP*BL];
    int m_busy, m_left, m_kind, m_status, m_valid, m_page, m_mod, m_prot;
    int m_target, m_cst;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            started = 1;
            m_busy = 0; m_left = 0; m_kind = 0; m_status = 0;
            m_valid = 0; m_page = 0; m_mod = 0; m_prot = 0;
            m_target = 0; m_cst = 0;
            for (int i = 0; i < NP*BL; i++) begin m_ce[i] = 0; m_ue[i] = 0; end
        end else begin
            if (inj_we) begin
                m_ce[int'(inj_page)*BL + int'(inj_blk)] = inj_ce;
                m_ue[int'(inj_page)*BL + int'(inj_blk)] = inj_ue;
            end
            if (m_busy != 0) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    case (m_kind)
                        1: begin m_mod = 0; m_prot = 0; m_status = 0; end
                        2: begin m_prot = 0; m_status = 0; end
                        3: m_status = 3;
                        default: begin
                            m_valid = 1; m_page = m_target;
                            m_mod = 0; m_prot = 0; m_status = m_cst;
                        end
                    endcase
                end
            end else if (discard_req) begin
                m_busy = 1; m_left = 1; m_kind = 1;
            end else if (unprot_req) begin
                int pn;
                pn = int'(addr) / WORDS;
                m_busy = 1;
                if (m_valid != 0 && m_page == pn) begin
                    m_left = 1; m_kind = 2;
                end else if (m_mod != 0 && (lp || m_prot != 0)) begin
                    m_left = 1; m_kind = 3;
                end else begin
                    bit ce, ue;
                    ce = 0; ue = 0;
                    for (int b = 0; b < BL; b++) begin
                        ce |= m_ce[(pn % NP)*BL + b];
                        ue |= m_ue[(pn % NP)*BL + b];
                    end
                    m_left = WORDS; m_kind = 4; m_target = pn;
                    m_cst = ue ? 2 : (ce ? 1 : 0);
                end
            end else if (buf_wr && m_valid != 0) begin
                m_mod = 1;
                if (lp) m_prot = 1;
            end
        end
    end

    task automatic cmpf(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare the design against the model on every falling edge.
    always @(negedge clk) begin
        if (started) begin
            cmpf("R8", "busy", int'(busy), m_busy);
            cmpf("R8", "status", int'(status), m_status);
            cmpf("R3", "valid", int'(res_valid), m_valid);
            cmpf("R3", "page", int'(res_page), m_page);
            cmpf("R11", "modified", int'(modified), m_mod);
            cmpf("R2", "protected", int'(protect), m_prot);
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cycles > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    task automatic tick(); @(negedge clk); #1; endtask

    task automatic cmd(bit u, bit d, logic [17:0] a, bit q);
        unprot_req = u; discard_req = d; addr = a; lp = q;
        tick();
        unprot_req = 0; discard_req = 0; lp = 0;
    endtask

    task automatic wait_idle();
        do tick(); while (busy);
    endtask

    task automatic bwrite(bit q);
        buf_wr = 1; lp = q; tick(); buf_wr = 0; lp = 0;
    endtask

    task automatic inject(int pg, bit blk, bit ce, bit ue);
        inj_we = 1; inj_page = 4'(pg); inj_blk = blk; inj_ce = ce; inj_ue = ue;
        tick();
        inj_we = 0;
    endtask

    initial begin
        repeat (4) tick();
        rst_n = 1;
        tick();
        // R1: reset state
        cmpf("R1", "busy", int'(busy), 0);
        cmpf("R1", "status", int'(status), 0);
        cmpf("R1", "valid", int'(res_valid), 0);
        // R9: write with nothing resident is ignored
        bwrite(1);
        tick();
        cmpf("R9", "modified", int'(modified), 0);
        // R3: first command always fetches; busy lasts WORDS cycles
        cmd(1, 0, 18'h10, 0);
        for (int k = 1; k < WORDS; k++) begin
            cmpf("R3", "busy during fetch", int'(busy), 1);
            tick();
        end
        tick();
        cmpf("R3", "busy after fetch", int'(busy), 0);
        cmpf("R3", "page", int'(res_page), 2);
        // R11: plain write marks modified only
        bwrite(0);
        tick();
        cmpf("R11", "modified", int'(modified), 1);
        cmpf("R11", "protected", int'(protect), 0);
        // Unprotected edits do not block a swap
        cmd(1, 0, 18'h28, 0);
        wait_idle();
        cmpf("R3", "page", int'(res_page), 5);
        // R11: protected write
        bwrite(1);
        tick();
        cmpf("R11", "protected", int'(protect), 1);
        // R4: refusal by stored protection
        cmd(1, 0, 18'h38, 0);
        wait_idle();
        cmpf("R4", "status", int'(status), 3);
        cmpf("R4", "page", int'(res_page), 5);
        // R2: unprotect on resident page
        cmd(1, 0, 18'h2C, 0);
        wait_idle();
        cmpf("R2", "protected", int'(protect), 0);
        cmpf("R2", "modified", int'(modified), 1);
        cmpf("R2", "status", int'(status), 0);
        // R4: refusal by qualifier at acceptance
        cmd(1, 0, 18'h38, 1);
        wait_idle();
        cmpf("R4", "status", int'(status), 3);
        // R7: discard
        cmd(0, 1, 18'h0, 0);
        wait_idle();
        cmpf("R7", "modified", int'(modified), 0);
        cmpf("R7", "page", int'(res_page), 5);
        cmpf("R7", "status", int'(status), 0);
        // R5: correctable only
        inject(7, 1, 1, 0);
        cmd(1, 0, 18'h38, 0);
        wait_idle();
        cmpf("R5", "status", int'(status), 1);
        // R6 and R12: mixed flags through an aliased page number (18 -> index 2)
        inject(2, 0, 1, 0);
        inject(2, 1, 0, 1);
        cmd(1, 0, 18'h90, 0);
        wait_idle();
        cmpf("R6", "status", int'(status), 2);
        cmpf("R12", "page", int'(res_page), 18);
        // R10: both strobes, discard wins
        bwrite(0);
        cmd(1, 1, 18'h48, 0);
        wait_idle();
        cmpf("R10", "page", int'(res_page), 18);
        cmpf("R10", "modified", int'(modified), 0);
        // R9: strobes and writes during a fetch are ignored
        cmd(1, 0, 18'h48, 0);
        cmd(0, 1, 18'h0, 0);
        bwrite(1);
        cmd(1, 0, 18'h10, 1);
        wait_idle();
        cmpf("R9", "page", int'(res_page), 9);
        cmpf("R9", "modified", int'(modified), 0);
        cmpf("R9", "protected", int'(protect), 0);
        cmpf("R9", "status", int'(status), 0);
        repeat (3) tick();
        finish_run();
    end

endmodule